// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

This block receives 8-bit frames from a one-wire serial data input, least-significant bit first, timed by a serial clock. The clock comes from one of two places, chosen by software. In internal mode the block divides the system clock by a programmable power of two and drives the result on its own clock output. In external mode it follows a clock supplied from outside, which it brings into the system clock domain through a synchronizer. Each finished byte is parked in a data buffer, and a level-sensitive interrupt stays high until software reads that buffer.

Software works through a small register port that has three registers: control, status and data buffer. The receiver only runs when the receive mode is selected and the start bit is set. There are two ways to stop it. Clearing the start bit is a graceful stop: the byte in progress finishes and lands in the buffer. Setting the abort bit is an immediate stop: the partial byte is thrown away. In internal mode the receiver holds its clock high between bytes while the buffer is unread, so no data can be lost. In external mode the sender sets the pace. An unread byte is then overwritten and a sticky overrun flag records it.

Top module: `sbr_receiver`

## Requirements
- R1: Bits are shifted in least-significant first: the first bit sampled in a byte appears at bit 0 of the data register (address 2), and the eighth at bit 7.
- R2: When the eighth bit of a byte is sampled, the byte is copied to the data register, status bit 1 (buffer full) is set and `irq` goes high on the same clock edge.
- R3: A start bit written while the control mode field (bits 3:2) is anything other than 01 starts nothing: status bit 0 stays 0 and `sclk_out` stays high.
- R4: In internal mode (control bit 4 = 0), while the buffer is full the serial clock is held high and no bits are taken; it resumes once the data register is read.
- R5: In external mode (control bit 4 = 1), bits are taken on each synchronized rising edge of `sclk_in` whatever the buffer state; a byte completing on an unread buffer overwrites it and sets status bit 2 (overrun), which a status read (address 1) clears.
- R6: Writing the control register with start (bit 0) cleared lets the byte in progress finish and reach the data register; status bit 0 then falls to 0.
- R7: Writing the control register with abort (bit 1) set clears the start bit, discards the partial byte and clears status bit 0 on the next edge; bits arriving afterwards are ignored until start is set again.
- R8: A control write that changes the mode field clears the data register to 0 and clears buffer full and `irq`.
- R9: Reading the data register clears buffer full and drops `irq`.
- R10: The internal clock idles high, toggles every 2^S system cycles (S = control bits 7:5), and data is sampled on its rising edge.
- R11: Status bit 0 (busy) is 1 while start is set in receive mode or a byte is partly received, and is 0 after reset.
- R12: The control register (address 0) reads back its written value, with the abort bit always reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after the read strobe |
| irq | output | 1 | Buffer-full interrupt request, level |
| sclk_in | input | 1 | Serial clock from outside (external mode) |
| sclk_out | output | 1 | Generated serial clock (internal mode) |
| sdata_in | input | 1 | Serial data input |

## Verification
The bench builds the block with its default parameters: 8-bit frames, a 3-bit divider select and a two-stage synchronizer. It drives divider selects 0 and 2, which give serial periods of 2 and 8 system cycles. With these short periods, full bytes, buffer stalls and mid-byte stops all happen within a few hundred cycles. In internal mode the bench model counts rising edges of `sclk_out` and compares `irq` on every clock. External-mode framing, overrun and the two stop paths are checked through register reads at points where the synchronizer delay has settled.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int REG_W     = 8;
  localparam int REG_AW    = 2;
  localparam int DIV_SEL_W = 3;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RX   = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 ext_clk;
    rx_mode_e             mode;
    logic                 abort;
    logic                 start;
  } ctrl_t;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             sclk,
  output logic             rise
);
  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] hcnt;
  logic [CW-1:0] last;

  assign last = (CW'(1) << sel) - CW'(1);
  assign rise = en && (hcnt == last) && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sclk <= 1'b1;
      hcnt <= '0;
    end else if (hcnt == last) begin
      sclk <= ~sclk;
      hcnt <= '0;
    end else begin
      hcnt <= hcnt + CW'(1);
    end
  end

  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> sclk);
endmodule

// File: rtl/sbr_shift.sv
module sbr_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          take,
  input  logic          sbit,
  output logic [DW-1:0] word_nxt,
  output logic          done,
  output logic          in_frame
);
  localparam int CNW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNW-1:0] LAST = CNW'(DW - 1);

  logic [DW-1:0]  sh;
  logic [CNW-1:0] cnt;

  assign word_nxt = {sbit, sh[DW-1:1]};
  assign done     = take && (cnt == LAST);
  assign in_frame = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh  <= '0;
      cnt <= '0;
    end else if (take) begin
      sh  <= word_nxt;
      cnt <= done ? '0 : cnt + CNW'(1);
    end
  end

  // R1
  progress_chk: assert property (@(posedge clk) disable iff (rst)
    take && !flush && !done |=> in_frame);
endmodule

// File: rtl/sbr_receiver.sv
module sbr_receiver
  import sbr_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdata_in
);
  ctrl_t               ctrl_q;
  ctrl_t               wctrl;
  logic                wr_ctrl, rd_stat, rd_data;
  logic                abort_w, mode_chg, flush;
  logic                armed, active, in_frame;
  logic [1:0]          sync_q;
  logic                ext_clk_d, ext_rise;
  logic                gen_en, int_rise, take, sbit;
  logic                done, frame_done;
  logic [FRAME_W-1:0]  word_nxt;
  logic [FRAME_W-1:0]  buf_q;
  logic                full_q, ovr_q;

  assign wctrl    = ctrl_t'(reg_wdata);
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
  assign rd_data  = reg_rd && (reg_addr == ADDR_DATA);
  assign abort_w  = wr_ctrl && wctrl.abort;
  assign mode_chg = wr_ctrl && (wctrl.mode != ctrl_q.mode);
  assign flush    = abort_w || mode_chg;

  assign armed  = ctrl_q.start && (ctrl_q.mode == MODE_RX);
  assign active = armed || in_frame;

  // external clock and data brought into the system domain together
  sbr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, sdata_in}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ext_clk_d <= 1'b0;
    else     ext_clk_d <= sync_q[1];
  end
  assign ext_rise = sync_q[1] && !ext_clk_d;

  assign gen_en = active && !full_q && !ctrl_q.ext_clk;

  sbr_clkgen #(.SEL_W(DIV_SEL_W)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .en   (gen_en),
    .sel  (ctrl_q.div_sel),
    .sclk (sclk_out),
    .rise (int_rise)
  );

  assign take = ctrl_q.ext_clk ? (ext_rise && active) : int_rise;
  assign sbit = ctrl_q.ext_clk ? sync_q[0] : sdata_in;

  sbr_shift #(.DW(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .take     (take),
    .sbit     (sbit),
    .word_nxt (word_nxt),
    .done     (done),
    .in_frame (in_frame)
  );

  assign frame_done = done && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q       <= wctrl;
      ctrl_q.abort <= 1'b0;
      if (wctrl.abort) ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (frame_done) begin
      buf_q  <= word_nxt;
      full_q <= 1'b1;
    end else if (mode_chg) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (rd_data) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   ovr_q <= 1'b0;
    else if (frame_done && full_q && !rd_data) ovr_q <= 1'b1;
    else if (rd_stat || mode_chg)              ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= ctrl_q;
        ADDR_STAT: reg_rdata <= {{(REG_W-3){1'b0}}, ovr_q, full_q, active};
        ADDR_DATA: reg_rdata <= REG_W'(buf_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign irq = full_q;

  // R2
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> irq);

  // R4
  stall_high_chk: assert property (@(posedge clk) disable iff (rst)
    full_q && !ctrl_q.ext_clk |-> sclk_out);

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done && full_q && !rd_data |=> ovr_q);

  // R6
  graceful_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && !wctrl.start && !flush && in_frame && !frame_done |=> active);

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> !active);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data && !frame_done |=> !irq);

  // R3
  idle_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !in_frame);
endmodule

// File: tb/tb_sbr_receiver.sv
module tb_sbr_receiver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sclk_out;
  logic       sclk_in = 1'b0, sdata_in = 1'b0;

  int checks = 0, fails = 0;

  sbr_receiver dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk_in(sclk_in), .sclk_out(sclk_out), .sdata_in(sdata_in)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int         m_cnt = 0, cyc = 0, rise_cnt = 0, last_rise = 0, period = 0;
  bit         m_run = 0, m_full = 0, m_ext = 0, track = 0, prev_sclk = 1;
  logic [1:0] m_mode = 2'b00;
  logic [7:0] m_sh = 0, m_buf = 0;
  bit         p_wr = 0, p_rd = 0;
  logic [7:0] p_wdata = 0;
  bit         bitq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (track && (m_run || m_cnt != 0) && sclk_out && !prev_sclk) begin
      m_sh = {sdata_in, m_sh[7:1]};
      m_cnt++;
      if (rise_cnt == 1) period = cyc - last_rise;
      last_rise = cyc;
      rise_cnt++;
      if (m_cnt == 8) begin m_cnt = 0; m_buf = m_sh; m_full = 1; end
      if (bitq.size() > 0) void'(bitq.pop_front());
      sdata_in = (bitq.size() > 0) ? bitq[0] : 1'b0;
    end
    prev_sclk = sclk_out;
    if (p_wr) begin
      if (p_wdata[3:2] != m_mode) begin m_full = 0; m_buf = 0; m_cnt = 0; end
      m_mode = p_wdata[3:2];
      if (p_wdata[1]) begin m_run = 0; m_cnt = 0; end
      else m_run = p_wdata[0] && (p_wdata[3:2] == 2'b01);
      m_ext = p_wdata[4];
      p_wr = 0;
    end
    if (p_rd) begin m_full = 0; p_rd = 0; end
    if (track) begin
      check(irq === m_full, "R2 irq level per clock", irq, m_full);
      if (m_full && !m_ext) check(sclk_out === 1'b1, "R4 clock held high", sclk_out, 1);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) begin p_wr = 1; p_wdata = d; end
    step();
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    if (a == 2'd2) p_rd = 1;
    step();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic load_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bitq.push_back(b[i]);
    sdata_in = bitq[0];
  endtask

  task automatic wait_full(input string req);
    int n = 0;
    while (!m_full && n < 5000) begin step(); n++; end
    check(m_full, req, m_full, 1);
  endtask

  task automatic ext_bit(input bit b);
    sclk_in = 0; sdata_in = b;
    repeat (3) step();
    sclk_in = 1;
    repeat (3) step();
  endtask

  task automatic ext_byte(input logic [7:0] b, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) ext_bit(b[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int r0, n;
    repeat (3) step();
    rst = 0;
    step();

    // reset state
    check(irq === 1'b0, "R2 reset irq", irq, 0);
    check(sclk_out === 1'b1, "R10 reset clock idle high", sclk_out, 1);
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R11 reset status", rd, 8'h00);

    // start without receive mode
    wr_reg(2'd0, 8'h01);
    n = 0;
    for (int i = 0; i < 30; i++) begin step(); if (sclk_out !== 1'b1) n++; end
    check(n == 0, "R3 no clock without receive mode", n, 0);
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R3 busy stays low", rd, 8'h00);
    wr_reg(2'd0, 8'h00);

    // control readback, abort reads as 0
    wr_reg(2'd0, 8'h46);
    rd_reg(2'd0, rd);
    check(rd === 8'h44, "R12 control readback", rd, 8'h44);
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R7 abort leaves idle", rd, 8'h00);
    wr_reg(2'd0, 8'h00);

    // internal clock, divider select 0, two bytes with a stall between
    track = 1; rise_cnt = 0;
    load_byte(8'hA5); load_byte(8'h3C);
    wr_reg(2'd0, 8'h05);
    wait_full("R2 first byte completes");
    check(period == 2, "R10 period for select 0", period, 2);
    r0 = rise_cnt;
    repeat (40) step();
    check(rise_cnt == r0, "R4 no bits taken while full", rise_cnt, r0);
    rd_reg(2'd1, rd);
    check(rd === 8'h03, "R11 busy and full while stalled", rd, 8'h03);
    rd_reg(2'd2, rd);
    check(rd === 8'hA5, "R1 first byte LSB first", rd, 8'hA5);
    check(rd === m_buf, "R1 model byte", rd, m_buf);
    check(irq === 1'b0, "R9 read drops irq", irq, 0);
    wait_full("R4 resumes after read");
    rd_reg(2'd2, rd);
    check(rd === 8'h3C, "R1 second byte", rd, 8'h3C);
    wr_reg(2'd0, 8'h04);
    repeat (5) step();
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R11 idle after stop", rd, 8'h00);

    // mode change clears the buffer
    load_byte(8'hE7);
    wr_reg(2'd0, 8'h05);
    wait_full("R2 byte before mode change");
    wr_reg(2'd0, 8'h00);
    step();
    check(irq === 1'b0, "R8 irq cleared by mode change", irq, 0);
    rd_reg(2'd2, rd);
    check(rd === 8'h00, "R8 data cleared by mode change", rd, 8'h00);
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R8 status after mode change", rd, 8'h00);

    // divider select 2 with a graceful stop mid-byte
    bitq.delete(); rise_cnt = 0;
    load_byte(8'h4B);
    wr_reg(2'd0, 8'h45);
    n = 0;
    while (m_cnt != 3 && n < 2000) begin step(); n++; end
    wr_reg(2'd0, 8'h44);
    rd_reg(2'd1, rd);
    check(rd === 8'h01, "R6 busy held during graceful stop", rd, 8'h01);
    wait_full("R6 byte finishes after stop");
    check(period == 8, "R10 period for select 2", period, 8);
    rd_reg(2'd1, rd);
    check(rd === 8'h02, "R6 busy low after last bit", rd, 8'h02);
    rd_reg(2'd2, rd);
    check(rd === 8'h4B, "R6 finished byte", rd, 8'h4B);

    // external clock mode
    track = 0;
    wr_reg(2'd0, 8'h15);
    ext_byte(8'h5A, 0, 7);
    ext_byte(8'hC3, 0, 7);
    repeat (4) step();
    rd_reg(2'd1, rd);
    check(rd === 8'h07, "R5 overrun flagged", rd, 8'h07);
    rd_reg(2'd1, rd);
    check(rd === 8'h03, "R5 status read clears overrun", rd, 8'h03);
    rd_reg(2'd2, rd);
    check(rd === 8'hC3, "R5 newer byte overwrites", rd, 8'hC3);

    ext_byte(8'h96, 0, 2);
    wr_reg(2'd0, 8'h14);
    rd_reg(2'd1, rd);
    check(rd === 8'h01, "R6 external stop keeps busy", rd, 8'h01);
    ext_byte(8'h96, 3, 7);
    repeat (4) step();
    rd_reg(2'd1, rd);
    check(rd === 8'h02, "R6 external stop completes", rd, 8'h02);
    rd_reg(2'd2, rd);
    check(rd === 8'h96, "R6 external stopped byte", rd, 8'h96);

    wr_reg(2'd0, 8'h15);
    ext_byte(8'hFF, 0, 2);
    wr_reg(2'd0, 8'h16);
    step();
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R7 abort clears busy", rd, 8'h00);
    ext_byte(8'hFF, 0, 1);
    repeat (4) step();
    rd_reg(2'd1, rd);
    check(rd === 8'h00, "R7 bits after abort ignored", rd, 8'h00);
    check(irq === 1'b0, "R7 no irq after abort", irq, 0);
    wr_reg(2'd0, 8'h15);
    ext_byte(8'h81, 0, 7);
    repeat (4) step();
    check(irq === 1'b1, "R2 external byte raises irq", irq, 1);
    rd_reg(2'd2, rd);
    check(rd === 8'h81, "R7 partial data discarded", rd, 8'h81);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule